// File: doc/BRIEF.md
# Triplicated I2C Coefficient Register File

This block is an I2C target that holds the coefficients of an on-chip inference engine in a small byte-wide register file and presents every byte at once on a parallel bus to the datapath. A controller on the two-wire bus addresses the block, sets a register pointer with the first data byte, and then writes or reads consecutive registers. The pointer steps by one after each byte. Coefficients may be rewritten at any time after reset, which changes the loaded algorithm without touching the datapath.

The block is meant for an environment where single-event upsets are expected. Everything with state is held in three identical copies: the input synchronisers, the protocol state machine, the shift register, the pointer and the storage. A bitwise majority of the three copies drives the next-state logic of every copy. As a result, a copy that has been flipped is overwritten with the agreed value on the next clock edge, and no single corrupted copy is ever visible at the outputs. An injection input lets a bench or a beam test invert a whole copy for one cycle.

Top module: `tmr_i2c_regfile`

## Requirements
- R1: During and right after reset, `coef_bus` is all zeros and `sda_oe` is 0.
- R2: The first byte after a START carries the 7-bit device address in bits 7:1 and the direction in bit 0 (1 = read). The block drives an ACK (pulls SDA low) only when the address equals `DEV_ADDR`. With any other address it stays silent and ignores the rest of the transfer.
- R3: In a write transfer, the first data byte loads the register pointer. Each later byte is stored at the pointer, the pointer advances by one, and every byte is acknowledged.
- R4: In a read transfer, the block sends the byte at the pointer MSB first and advances the pointer. It sends the next byte when the controller ACKs. After a NACK it releases SDA and waits for the next START. The pointer is kept between transfers.
- R5: A pointer value at or above `NREG` selects no register: such writes are discarded and such reads return 0x00.
- R6: A START at any point restarts address reception and discards a partially received byte. A STOP returns the block to idle with SDA released.
- R7: Inverting every state bit of any single copy for one cycle changes neither `coef_bus` nor `sda_oe` nor any transfer.
- R8: A corrupted copy is restored on the next clock edge. Upsets that hit a different copy on every consecutive cycle therefore still have no effect at the ports.
- R9: Register i appears on `coef_bus[8*i+7:8*i]` and takes a newly written value without any further action.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Bus clock as seen at the pad |
| sda_in | input | 1 | Bus data as seen at the pad (wired-AND line) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| upset_inj | input | 3 | Bit k inverts all state of copy k for one cycle |
| coef_bus | output | NREG*8 | Voted register contents, register i at bits 8i+7:8i |

## Verification
A wrong byte in the storage shows on `coef_bus` two clock cycles after the SCL falling edge that completes the byte. A wrong pointer shows on the next read, as a byte that does not match the model. A state-machine error shows as a missing or extra ACK, or as SDA held low, within the same bus byte. A single corrupted copy must never reach the ports. If the feedback scrubbing were lost, a second upset on another copy a cycle later would show at the outputs at once. Upsets are therefore injected into a rotating copy on every cycle during live reads and writes.

// File: rtl/tmr_i2c_pkg.sv
package tmr_i2c_pkg;

   typedef enum logic [2:0] {
      ST_IDLE, ST_ADDR, ST_AACK, ST_PTR,
      ST_DACK, ST_WDATA, ST_RDATA, ST_RACK
   } fsm_e;

   // protocol state of one copy (storage is kept separately)
   typedef struct packed {
      logic       scl_q1;
      logic       scl_q2;
      logic       sda_q1;
      logic       sda_q2;
      fsm_e       fsm;
      logic [3:0] cnt;
      logic [7:0] shr;
      logic [7:0] ptr;
      logic       rw;
      logic       mack;
      logic       drive;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

   localparam ctrl_t CTRL_RST = '{
      scl_q1: 1'b1, scl_q2: 1'b1, sda_q1: 1'b1, sda_q2: 1'b1,
      fsm: ST_IDLE, cnt: 4'd0, shr: 8'd0, ptr: 8'd0,
      rw: 1'b0, mack: 1'b0, drive: 1'b0
   };

endpackage

// File: rtl/tmr_vote.sv
module tmr_vote #(
   parameter int W = 8
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [W-1:0] c_i,
   output logic [W-1:0] y_o
);
   initial assert (W >= 1) else $error("tmr_vote: W must be positive");

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign y_o[i] = (a_i[i] & b_i[i]) | (a_i[i] & c_i[i]) | (b_i[i] & c_i[i]);
   end
endmodule

// File: rtl/i2c_tgt_next.sv
module i2c_tgt_next
   import tmr_i2c_pkg::*;
#(
   parameter int         NREG     = 16,
   parameter logic [6:0] DEV_ADDR = 7'h2A,
   localparam int        RW       = NREG * 8
) (
   input  ctrl_t         cur_i,
   input  logic [RW-1:0] regs_i,
   input  logic          scl_i,
   input  logic          sda_i,
   output ctrl_t         nxt_o,
   output logic [RW-1:0] regs_o
);
   logic       scl_rise, scl_fall, start_c, stop_c;
   logic [7:0] rbyte;

   assign scl_rise = cur_i.scl_q1 & ~cur_i.scl_q2;
   assign scl_fall = ~cur_i.scl_q1 & cur_i.scl_q2;
   assign start_c  = cur_i.scl_q1 & cur_i.scl_q2 & cur_i.sda_q2 & ~cur_i.sda_q1;
   assign stop_c   = cur_i.scl_q1 & cur_i.scl_q2 & ~cur_i.sda_q2 & cur_i.sda_q1;

   // byte at the pointer, zero when the pointer is past the file
   always_comb begin
      rbyte = 8'h00;
      for (int i = 0; i < NREG; i++)
         if (cur_i.ptr == 8'(i)) rbyte = regs_i[i*8 +: 8];
   end

   always_comb begin
      nxt_o        = cur_i;
      regs_o       = regs_i;
      nxt_o.scl_q1 = scl_i;
      nxt_o.scl_q2 = cur_i.scl_q1;
      nxt_o.sda_q1 = sda_i;
      nxt_o.sda_q2 = cur_i.sda_q1;
      if (start_c) begin
         nxt_o.fsm   = ST_ADDR;
         nxt_o.cnt   = 4'd0;
         nxt_o.drive = 1'b0;
      end else if (stop_c) begin
         nxt_o.fsm   = ST_IDLE;
         nxt_o.cnt   = 4'd0;
         nxt_o.drive = 1'b0;
      end else begin
         unique case (cur_i.fsm)
            ST_IDLE: ;
            ST_ADDR, ST_PTR, ST_WDATA: begin
               if (scl_rise) begin
                  nxt_o.shr = {cur_i.shr[6:0], cur_i.sda_q1};
                  nxt_o.cnt = cur_i.cnt + 4'd1;
               end else if (scl_fall && cur_i.cnt == 4'd8) begin
                  nxt_o.cnt   = 4'd0;
                  nxt_o.drive = 1'b1;
                  if (cur_i.fsm == ST_ADDR) begin
                     if (cur_i.shr[7:1] == DEV_ADDR) begin
                        nxt_o.rw  = cur_i.shr[0];
                        nxt_o.fsm = ST_AACK;
                     end else begin
                        nxt_o.drive = 1'b0;
                        nxt_o.fsm   = ST_IDLE;
                     end
                  end else if (cur_i.fsm == ST_PTR) begin
                     nxt_o.ptr = cur_i.shr;
                     nxt_o.fsm = ST_DACK;
                  end else begin
                     for (int i = 0; i < NREG; i++)
                        if (cur_i.ptr == 8'(i)) regs_o[i*8 +: 8] = cur_i.shr;
                     nxt_o.ptr = cur_i.ptr + 8'd1;
                     nxt_o.fsm = ST_DACK;
                  end
               end
            end
            ST_AACK: begin
               if (scl_fall) begin
                  if (cur_i.rw) begin
                     nxt_o.shr   = rbyte;
                     nxt_o.drive = ~rbyte[7];
                     nxt_o.cnt   = 4'd0;
                     nxt_o.fsm   = ST_RDATA;
                  end else begin
                     nxt_o.drive = 1'b0;
                     nxt_o.fsm   = ST_PTR;
                  end
               end
            end
            ST_DACK: begin
               if (scl_fall) begin
                  nxt_o.drive = 1'b0;
                  nxt_o.fsm   = ST_WDATA;
               end
            end
            ST_RDATA: begin
               if (scl_rise) begin
                  nxt_o.cnt = cur_i.cnt + 4'd1;
               end else if (scl_fall) begin
                  if (cur_i.cnt == 4'd8) begin
                     nxt_o.drive = 1'b0;
                     nxt_o.ptr   = cur_i.ptr + 8'd1;
                     nxt_o.cnt   = 4'd0;
                     nxt_o.fsm   = ST_RACK;
                  end else begin
                     nxt_o.shr   = {cur_i.shr[6:0], 1'b0};
                     nxt_o.drive = ~cur_i.shr[6];
                  end
               end
            end
            ST_RACK: begin
               if (scl_rise) begin
                  nxt_o.mack = ~cur_i.sda_q1;
               end else if (scl_fall) begin
                  if (cur_i.mack) begin
                     nxt_o.shr   = rbyte;
                     nxt_o.drive = ~rbyte[7];
                     nxt_o.cnt   = 4'd0;
                     nxt_o.fsm   = ST_RDATA;
                  end else begin
                     nxt_o.fsm = ST_IDLE;
                  end
               end
            end
            default: nxt_o.fsm = ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/tmr_i2c_regfile.sv
module tmr_i2c_regfile
   import tmr_i2c_pkg::*;
#(
   parameter int         NREG     = 16,
   parameter logic [6:0] DEV_ADDR = 7'h2A,
   localparam int        RW       = NREG * 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_in,
   input  logic          sda_in,
   output logic          sda_oe,
   input  logic [2:0]    upset_inj,
   output logic [RW-1:0] coef_bus
);
   initial begin
      assert (NREG >= 1 && NREG <= 256) else $error("NREG must lie in 1..256");
      assert (DEV_ADDR >= 7'h08 && DEV_ADDR <= 7'h77) else $error("DEV_ADDR is a reserved address");
   end

   logic [CTRL_W-1:0] c_v_raw;
   ctrl_t             c_v;
   logic [RW-1:0]     r_v;

   assign c_v = ctrl_t'(c_v_raw);

   // three complete copies; each reloads from the voted state
   for (genvar k = 0; k < 3; k++) begin : g_copy
      logic [CTRL_W-1:0] c_q;
      logic [RW-1:0]     r_q;
      ctrl_t             c_n;
      logic [RW-1:0]     r_n;

      i2c_tgt_next #(.NREG(NREG), .DEV_ADDR(DEV_ADDR)) u_next (
         .cur_i (c_v),
         .regs_i(r_v),
         .scl_i (scl_in),
         .sda_i (sda_in),
         .nxt_o (c_n),
         .regs_o(r_n)
      );

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            c_q <= CTRL_RST;
            r_q <= '0;
         end else begin
            c_q <= c_n ^ {CTRL_W{upset_inj[k]}};
            r_q <= r_n ^ {RW{upset_inj[k]}};
         end
      end
   end

   tmr_vote #(.W(CTRL_W)) u_vote_ctrl (
      .a_i(g_copy[0].c_q), .b_i(g_copy[1].c_q), .c_i(g_copy[2].c_q), .y_o(c_v_raw)
   );
   tmr_vote #(.W(RW)) u_vote_regs (
      .a_i(g_copy[0].r_q), .b_i(g_copy[1].r_q), .c_i(g_copy[2].r_q), .y_o(r_v)
   );

   assign coef_bus = r_v;
   assign sda_oe   = c_v.drive;

   logic stop_v;
   assign stop_v = c_v.scl_q1 & c_v.scl_q2 & ~c_v.sda_q2 & c_v.sda_q1;

   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (coef_bus == '0 && !sda_oe));

   // R8
   copies_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(upset_inj) == 3'b000) |->
         (g_copy[0].c_q == g_copy[1].c_q && g_copy[1].c_q == g_copy[2].c_q &&
          g_copy[0].r_q == g_copy[1].r_q && g_copy[1].r_q == g_copy[2].r_q));

   // R3
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (c_v.ptr != $past(c_v.ptr)) |->
         (c_v.ptr == $past(c_v.ptr) + 8'd1 || $past(c_v.fsm) == ST_PTR));

   // R2
   sda_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sda_oe |-> (c_v.fsm inside {ST_AACK, ST_DACK, ST_RDATA}));

   // R6
   stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(stop_v) |-> (c_v.fsm == ST_IDLE && !sda_oe));
endmodule

// File: tb/sim_tmr_i2c_regfile.sv
module sim_tmr_i2c_regfile;
   localparam int         NREG = 16;
   localparam logic [6:0] AD   = 7'h2A;
   localparam int         Q    = 5;

   logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, csda = 1'b1;
   logic [2:0] upset = 3'b000;
   logic sda_oe;
   logic [NREG*8-1:0] coef;
   wire sda_line = csda & ~sda_oe;

   always #5 clk = ~clk;

   tmr_i2c_regfile #(.NREG(NREG), .DEV_ADDR(AD)) u0 (
      .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
      .sda_oe(sda_oe), .upset_inj(upset), .coef_bus(coef)
   );

   int checks = 0, fails = 0, mptr = 0;
   logic [7:0] mdl [NREG];
   bit busy = 1'b0, ended = 1'b0;

   task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [NREG*8-1:0] mvec();
      logic [NREG*8-1:0] v;
      for (int i = 0; i < NREG; i++) v[i*8 +: 8] = mdl[i];
      return v;
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // per-clock comparison of the bus against the model (R9, R7, R2, R6)
   always @(negedge clk)
      if (rst_n && !busy && !ended)
         chk(coef === mvec(), "R9 coef_bus vs model", coef, mvec());

   task automatic do_start();
      csda = 1'b1; tick(Q);
      if (!scl) begin scl = 1'b1; tick(Q); end
      csda = 1'b0; tick(Q);
      scl = 1'b0; tick(Q);
   endtask

   task automatic do_stop();
      csda = 1'b0; tick(Q);
      scl = 1'b1; tick(Q);
      csda = 1'b1; tick(2*Q);
   endtask

   task automatic send_bits(input logic [7:0] b, input int nb);
      for (int i = 7; i > 7 - nb; i--) begin
         csda = b[i]; tick(Q);
         scl = 1'b1; tick(2*Q);
         scl = 1'b0; tick(Q);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      send_bits(b, 8);
      csda = 1'b1; tick(Q);
      scl = 1'b1; tick(Q);
      ack = !sda_line; tick(Q);
      scl = 1'b0; tick(Q);
   endtask

   task automatic recv_byte(output logic [7:0] b, input bit give_ack);
      for (int i = 7; i >= 0; i--) begin
         csda = 1'b1; tick(Q);
         scl = 1'b1; tick(Q);
         b[i] = sda_line; tick(Q);
         scl = 1'b0; tick(Q);
      end
      csda = give_ack ? 1'b0 : 1'b1; tick(Q);
      scl = 1'b1; tick(2*Q);
      scl = 1'b0; tick(Q);
      csda = 1'b1;
   endtask

   task automatic wr_seq(input logic [7:0] ptr, input logic [7:0] d[$]);
      bit ack;
      int p;
      do_start();
      send_byte({AD, 1'b0}, ack); chk(ack, "R2 own address ack", ack, 1);
      send_byte(ptr, ack);        chk(ack, "R3 pointer byte ack", ack, 1);
      p = ptr;
      foreach (d[j]) begin
         busy = 1'b1;
         send_byte(d[j], ack);
         chk(ack, "R3 data byte ack", ack, 1);
         if (p < NREG) mdl[p] = d[j];
         p = (p + 1) % 256;
         busy = 1'b0;
      end
      do_stop();
      mptr = p;
   endtask

   task automatic rd_body(input int n);
      logic [7:0] b, e;
      bit ack;
      send_byte({AD, 1'b1}, ack); chk(ack, "R2 read address ack", ack, 1);
      for (int k = 0; k < n; k++) begin
         recv_byte(b, k < n - 1);
         e = (mptr < NREG) ? mdl[mptr] : 8'h00;
         if (mptr < NREG) chk(b === e, "R4 read byte", b, e);
         else             chk(b === e, "R5 read past file", b, e);
         mptr = (mptr + 1) % 256;
      end
      do_stop();
      chk(sda_oe === 1'b0, "R4 SDA released after NACK", sda_oe, 0);
   endtask

   task automatic rd_seq(input logic [7:0] ptr, input int n);
      bit ack;
      do_start();
      send_byte({AD, 1'b0}, ack); chk(ack, "R2 own address ack", ack, 1);
      send_byte(ptr, ack);        chk(ack, "R3 pointer byte ack", ack, 1);
      mptr = ptr;
      do_start();
      rd_body(n);
   endtask

   task automatic rd_cur(input int n);
      do_start();
      rd_body(n);
   endtask

   initial begin
      bit ack;
      for (int i = 0; i < NREG; i++) mdl[i] = 8'h00;
      tick(5);
      chk(coef === '0, "R1 bus clear in reset", coef, 0);
      chk(sda_oe === 1'b0, "R1 SDA released in reset", sda_oe, 0);
      rst_n = 1'b1;
      tick(1);
      chk(coef === '0, "R1 bus clear after reset", coef, 0);
      chk(sda_oe === 1'b0, "R1 SDA released after reset", sda_oe, 0);
      tick(4);

      // R3 / R4: burst write then read back
      wr_seq(8'd0, '{8'h11, 8'hA2, 8'h3C, 8'hF0});
      rd_seq(8'd0, 4);
      rd_cur(2);                          // R4 pointer kept across transfers

      // R5: burst across the end of the file
      wr_seq(8'd14, '{8'h5E, 8'hC7, 8'h99, 8'h42});
      rd_seq(8'd14, 4);

      // R2: other address is ignored
      do_start();
      send_byte({AD ^ 7'h01, 1'b0}, ack); chk(!ack, "R2 no ack for other address", ack, 0);
      send_byte(8'h02, ack);              chk(!ack, "R2 rest of transfer ignored", ack, 0);
      send_byte(8'hEE, ack);              chk(!ack, "R2 rest of transfer ignored", ack, 0);
      do_stop();
      chk(coef === mvec(), "R2 storage untouched", coef, mvec());

      // R6: START inside a data byte drops the partial byte
      do_start();
      send_byte({AD, 1'b0}, ack);
      send_byte(8'd3, ack);
      send_bits(8'hB5, 4);
      do_start();
      send_byte({AD, 1'b0}, ack); chk(ack, "R6 restart address ack", ack, 1);
      send_byte(8'd5, ack);       chk(ack, "R6 restart pointer ack", ack, 1);
      busy = 1'b1;
      send_byte(8'h5A, ack);      chk(ack, "R6 restart data ack", ack, 1);
      mdl[5] = 8'h5A;
      busy = 1'b0;
      do_stop();
      chk(sda_oe === 1'b0, "R6 idle after stop", sda_oe, 0);
      rd_seq(8'd3, 3);

      // R6: STOP inside a data byte
      do_start();
      send_byte({AD, 1'b0}, ack);
      send_byte(8'd7, ack);
      send_bits(8'h00, 3);
      do_stop();
      chk(sda_oe === 1'b0, "R6 idle after early stop", sda_oe, 0);
      rd_seq(8'd7, 1);

      // R9: rewrite at any time, lane position
      wr_seq(8'd0, '{8'hFF});
      tick(2);
      chk(coef[7:0] === 8'hFF, "R9 lane 0 rewritten", coef[7:0], 8'hFF);
      chk(coef[15:8] === mdl[1], "R9 lane 1 kept", coef[15:8], mdl[1]);

      // R7 / R8: upsets while idle, one copy per cycle
      upset = 3'b001; tick(1);
      upset = 3'b010; tick(1);
      upset = 3'b100; tick(1);
      upset = 3'b000;
      chk(coef === mvec(), "R8 bus after rotating upsets", coef, mvec());
      chk(sda_oe === 1'b0, "R7 SDA after upsets", sda_oe, 0);

      // R8: rotating upsets during a read
      fork
         rd_seq(8'd0, 5);
         begin
            for (int k = 0; k < 600; k++) begin
               upset = 3'(1 << (k % 3));
               tick(1);
            end
            upset = 3'b000;
         end
      join

      // R7: single-copy upsets every other cycle during a write
      fork
         wr_seq(8'd8, '{8'h81, 8'h7E, 8'h24});
         begin
            for (int k = 0; k < 800; k++) begin
               upset = (k % 2 == 0) ? 3'(1 << ((k / 2) % 3)) : 3'b000;
               tick(1);
            end
            upset = 3'b000;
         end
      join
      rd_seq(8'd8, 3);

      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule